// File: doc/BRIEF.md
# Graphics Command Port Decoder

This block sits behind a 32-bit graphics command port and turns a stream of command words into a set of drawing-state registers. A word is taken on every clock edge where `word_valid` is high; the port never applies back-pressure. The top byte of the first word of a command is the opcode. The opcode fixes how many words the command spans and which register group it updates. Words are gathered in a small buffer while a countdown tracks how many are still owed. When the countdown reaches zero, the completed command is applied to the drawing state.

The opcodes handled are a no-op and six one-word state commands: drawing mode, texture window, the two drawing-area corners, drawing offset and mask control. The buffer and countdown are sized by parameter so that longer commands can be added without reworking the framing. An opcode the block does not know, or a drawing-mode word that asks for the unsupported texture depth code 3, is discarded. Such a word raises a sticky error flag and leaves every state register as it was.

Top module: `gcmd_decoder`

## Requirements
- R1: After a synchronous reset every state output is zero and `cmd_error` is low.
- R2: The opcode is `word_data[31:23+1]` (bits 31:24) of the first word of a command. A one-word command accepted on clock edge N is visible on the outputs after edge N+1, and not after edge N.
- R3: Opcode 0x00 is accepted as a one-word command and changes no output.
- R4: Opcode 0xE1 loads the drawing mode as follows. Texture page X is bits 3:0 and texture page Y is bit 4. The blend mode is bits 6:5 and the texture depth is bits 8:7. Dither enable is bit 9 and display-area drawing is bit 10. Texturing off is bit 11. Rectangle X flip is bit 12 and rectangle Y flip is bit 13. Bits 23:14 are ignored.
- R5: An 0xE1 word whose bits 8:7 equal 3 sets `cmd_error` and leaves the drawing-mode outputs unchanged.
- R6: Opcode 0xE2 loads four 5-bit texture-window fields: mask X from bits 4:0, mask Y from bits 9:5, offset X from bits 14:10 and offset Y from bits 19:15.
- R7: Opcode 0xE3 loads the upper-left corner and 0xE4 loads the lower-right corner. In both, X comes from bits 9:0 and Y from bits 19:10. Commands sent on back-to-back cycles are each framed and applied.
- R8: Opcode 0xE5 loads an 11-bit X from bits 10:0 and an 11-bit Y from bits 21:11. Both are presented as 16-bit two's-complement values with the sign extended.
- R9: Opcode 0xE6 sets the force-mask output from bit 0 and the preserve-masked output from bit 1.
- R10: An opcode other than 0x00 and 0xE1 to 0xE6 sets `cmd_error` and changes no state output. The flag then stays high until reset, while later legal commands are still applied.
- R11: On cycles with `word_valid` low, no output changes, whatever `word_data` holds.
- R12: `word_ready` is high in every cycle, in reset and out of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Command word present this cycle |
| word_data | input | 32 | Command word |
| word_ready | output | 1 | Always high: a word is taken whenever valid |
| tpage_x | output | 4 | Texture page X base |
| tpage_y | output | 1 | Texture page Y base |
| blend_mode | output | 2 | Semi-transparency mode |
| tex_depth | output | 2 | Texture colour depth code |
| dither_en | output | 1 | Dithering enable |
| disp_draw_en | output | 1 | Drawing to the displayed area allowed |
| tex_off | output | 1 | Texturing disabled |
| rect_flip_x | output | 1 | Rectangle texture X flip |
| rect_flip_y | output | 1 | Rectangle texture Y flip |
| twin_mask_x | output | 5 | Texture window mask X |
| twin_mask_y | output | 5 | Texture window mask Y |
| twin_ofs_x | output | 5 | Texture window offset X |
| twin_ofs_y | output | 5 | Texture window offset Y |
| clip_x0 | output | 10 | Drawing area left |
| clip_y0 | output | 10 | Drawing area top |
| clip_x1 | output | 10 | Drawing area right |
| clip_y1 | output | 10 | Drawing area bottom |
| org_x | output | 16 | Drawing offset X, sign-extended |
| org_y | output | 16 | Drawing offset Y, sign-extended |
| mask_force | output | 1 | Force mask bit on writes |
| mask_keep | output | 1 | Preserve masked pixels |
| cmd_error | output | 1 | Sticky illegal-command flag |

## Verification
The assertions assume that reset is held for at least one edge before any word is offered. They also assume that `word_data` carries known values whenever `word_valid` is high, because opcode legality is judged on the raw top byte. The bench asserts reset first and drives every input at the falling clock edge. It keeps `word_data` at defined values throughout, including the idle cycles where garbage is offered with `word_valid` low. Its only illegal words are an unknown opcode and a depth-3 drawing-mode word, both sent after reset.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;

    localparam int OPC_W   = 8;
    localparam int OPC_LSB = 24;
    localparam int OFS_W   = 11;
    localparam int ORG_W   = 16;
    localparam int CRD_W   = 10;
    localparam int TW_W    = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP     = 8'h00,
        OP_MODE    = 8'hE1,
        OP_TEXWIN  = 8'hE2,
        OP_CLIP_UL = 8'hE3,
        OP_CLIP_LR = 8'hE4,
        OP_ORIGIN  = 8'hE5,
        OP_MASK    = 8'hE6
    } gcmd_op_e;

    typedef struct packed {
        logic [3:0] page_x;
        logic       page_y;
        logic [1:0] blend;
        logic [1:0] depth;
        logic       dither;
        logic       disp_draw;
        logic       tex_off;
        logic       flip_x;
        logic       flip_y;
    } mode_t;

    typedef struct packed {
        logic [TW_W-1:0] mask_x;
        logic [TW_W-1:0] mask_y;
        logic [TW_W-1:0] ofs_x;
        logic [TW_W-1:0] ofs_y;
    } texwin_t;

    typedef struct packed {
        logic [CRD_W-1:0] x0;
        logic [CRD_W-1:0] y0;
        logic [CRD_W-1:0] x1;
        logic [CRD_W-1:0] y1;
    } clip_t;

    typedef struct packed {
        logic [OFS_W-1:0] x;
        logic [OFS_W-1:0] y;
    } origin_t;

    typedef struct packed {
        logic force_set;
        logic keep;
    } maskctl_t;

    typedef struct packed {
        mode_t    mode;
        texwin_t  twin;
        clip_t    clip;
        origin_t  org;
        maskctl_t msk;
    } draw_state_t;

    // Number of words a command spans; zero marks an unknown opcode.
    function automatic int unsigned cmd_words(input logic [OPC_W-1:0] op);
        case (op)
            OP_NOP, OP_MODE, OP_TEXWIN, OP_CLIP_UL,
            OP_CLIP_LR, OP_ORIGIN, OP_MASK: return 1;
            default:                        return 0;
        endcase
    endfunction

    // A known opcode is still refused when a drawing-mode word asks for depth code 3.
    function automatic logic cmd_legal(input logic [OPC_W-1:0] op,
                                       input logic [1:0]       depth);
        if (cmd_words(op) == 0)
            return 1'b0;
        if ((op == OP_MODE) && (depth == 2'b11))
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/gcmd_framer.sv
module gcmd_framer
    import gcmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              exec_o,
    output logic [OPC_W-1:0]  exec_op_o,
    output logic [WORD_W-1:0] exec_word_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] words;
        logic [CNT_W-1:0]             remain;
        logic [PTR_W-1:0]             ptr;
        logic                         exec;
        logic [OPC_W-1:0]             op;
        logic                         err;
    } frame_t;

    frame_t fr_d, fr_q;

    logic [OPC_W-1:0] op_in;
    logic [CNT_W-1:0] len_in;
    logic             legal_in;

    assign op_in    = in_word[OPC_LSB +: OPC_W];
    assign len_in   = CNT_W'(cmd_words(op_in));
    assign legal_in = cmd_legal(op_in, in_word[8:7]);

    always_comb begin
        fr_d      = fr_q;
        fr_d.exec = 1'b0;
        if (in_valid) begin
            if (fr_q.remain == '0) begin
                if (!legal_in) begin
                    fr_d.err = 1'b1;
                end else begin
                    fr_d.words    = '0;
                    fr_d.words[0] = in_word;
                    fr_d.ptr      = PTR_W'(1);
                    fr_d.op       = op_in;
                    fr_d.remain   = len_in - CNT_W'(1);
                    fr_d.exec     = (len_in == CNT_W'(1));
                end
            end else begin
                fr_d.words[fr_q.ptr] = in_word;
                fr_d.ptr             = fr_q.ptr + PTR_W'(1);
                fr_d.remain          = fr_q.remain - CNT_W'(1);
                fr_d.exec            = (fr_q.remain == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fr_q <= '0;
        else     fr_q <= fr_d;
    end

    assign exec_o      = fr_q.exec;
    assign exec_op_o   = fr_q.op;
    assign exec_word_o = fr_q.words[0];
    assign err_o       = fr_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) fr_q.err |=> fr_q.err); // R10
    AST_BAD_OP_DROPPED: assert property (@(posedge clk) disable iff (rst) (in_valid && fr_q.remain == '0 && !legal_in) |=> (!fr_q.exec && fr_q.remain == '0 && fr_q.err)); // R10
    AST_EXEC_FROM_WORD: assert property (@(posedge clk) disable iff (rst) fr_q.exec |-> $past(in_valid)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!fr_q.exec && $stable(fr_q.remain))); // R11

endmodule

// File: rtl/gcmd_state_regs.sv
module gcmd_state_regs
    import gcmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [OPC_W-1:0]  op_i,
    input  logic [WORD_W-1:0] word_i,
    output draw_state_t       state_o
);

    draw_state_t st_d, st_q;

    logic unused_hi;
    assign unused_hi = ^word_i[WORD_W-1:22];

    always_comb begin
        st_d = st_q;
        if (exec_i) begin
            case (op_i)
                OP_MODE: begin
                    st_d.mode.page_x    = word_i[3:0];
                    st_d.mode.page_y    = word_i[4];
                    st_d.mode.blend     = word_i[6:5];
                    st_d.mode.depth     = word_i[8:7];
                    st_d.mode.dither    = word_i[9];
                    st_d.mode.disp_draw = word_i[10];
                    st_d.mode.tex_off   = word_i[11];
                    st_d.mode.flip_x    = word_i[12];
                    st_d.mode.flip_y    = word_i[13];
                end
                OP_TEXWIN: begin
                    st_d.twin.mask_x = word_i[4:0];
                    st_d.twin.mask_y = word_i[9:5];
                    st_d.twin.ofs_x  = word_i[14:10];
                    st_d.twin.ofs_y  = word_i[19:15];
                end
                OP_CLIP_UL: begin
                    st_d.clip.x0 = word_i[9:0];
                    st_d.clip.y0 = word_i[19:10];
                end
                OP_CLIP_LR: begin
                    st_d.clip.x1 = word_i[9:0];
                    st_d.clip.y1 = word_i[19:10];
                end
                OP_ORIGIN: begin
                    st_d.org.x = word_i[10:0];
                    st_d.org.y = word_i[21:11];
                end
                OP_MASK: begin
                    st_d.msk.force_set = word_i[0];
                    st_d.msk.keep      = word_i[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_o = st_q;

    AST_HOLD_NO_EXEC: assert property (@(posedge clk) disable iff (rst) !exec_i |=> $stable(st_q)); // R11
    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst) (exec_i && op_i == OP_NOP) |=> $stable(st_q)); // R3
    AST_NO_DEPTH3: assert property (@(posedge clk) disable iff (rst) st_q.mode.depth != 2'b11); // R5

endmodule

// File: rtl/gcmd_decoder.sv
module gcmd_decoder
    import gcmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic [3:0]        tpage_x,
    output logic              tpage_y,
    output logic [1:0]        blend_mode,
    output logic [1:0]        tex_depth,
    output logic              dither_en,
    output logic              disp_draw_en,
    output logic              tex_off,
    output logic              rect_flip_x,
    output logic              rect_flip_y,
    output logic [4:0]        twin_mask_x,
    output logic [4:0]        twin_mask_y,
    output logic [4:0]        twin_ofs_x,
    output logic [4:0]        twin_ofs_y,
    output logic [9:0]        clip_x0,
    output logic [9:0]        clip_y0,
    output logic [9:0]        clip_x1,
    output logic [9:0]        clip_y1,
    output logic [15:0]       org_x,
    output logic [15:0]       org_y,
    output logic              mask_force,
    output logic              mask_keep,
    output logic              cmd_error
);

    localparam int EXT_W = ORG_W - OFS_W;

    logic              exec;
    logic [OPC_W-1:0]  exec_op;
    logic [WORD_W-1:0] exec_word;
    draw_state_t       st;

    gcmd_framer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (word_valid),
        .in_word     (word_data),
        .exec_o      (exec),
        .exec_op_o   (exec_op),
        .exec_word_o (exec_word),
        .err_o       (cmd_error)
    );

    gcmd_state_regs #(.WORD_W(WORD_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .exec_i  (exec),
        .op_i    (exec_op),
        .word_i  (exec_word),
        .state_o (st)
    );

    assign word_ready   = 1'b1;
    assign tpage_x      = st.mode.page_x;
    assign tpage_y      = st.mode.page_y;
    assign blend_mode   = st.mode.blend;
    assign tex_depth    = st.mode.depth;
    assign dither_en    = st.mode.dither;
    assign disp_draw_en = st.mode.disp_draw;
    assign tex_off      = st.mode.tex_off;
    assign rect_flip_x  = st.mode.flip_x;
    assign rect_flip_y  = st.mode.flip_y;
    assign twin_mask_x  = st.twin.mask_x;
    assign twin_mask_y  = st.twin.mask_y;
    assign twin_ofs_x   = st.twin.ofs_x;
    assign twin_ofs_y   = st.twin.ofs_y;
    assign clip_x0      = st.clip.x0;
    assign clip_y0      = st.clip.y0;
    assign clip_x1      = st.clip.x1;
    assign clip_y1      = st.clip.y1;
    assign org_x        = {{EXT_W{st.org.x[OFS_W-1]}}, st.org.x};
    assign org_y        = {{EXT_W{st.org.y[OFS_W-1]}}, st.org.y};
    assign mask_force   = st.msk.force_set;
    assign mask_keep    = st.msk.keep;

    AST_ORG_SIGN: assert property (@(posedge clk) disable iff (rst) (org_x[15] == org_x[10]) && (org_y[15] == org_y[10])); // R8

endmodule

// File: tb/gcmd_decoder_tb.sv
`timescale 1ns/100ps
module gcmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic [3:0]  tpage_x;
    logic        tpage_y;
    logic [1:0]  blend_mode, tex_depth;
    logic        dither_en, disp_draw_en, tex_off, rect_flip_x, rect_flip_y;
    logic [4:0]  twin_mask_x, twin_mask_y, twin_ofs_x, twin_ofs_y;
    logic [9:0]  clip_x0, clip_y0, clip_x1, clip_y1;
    logic [15:0] org_x, org_y;
    logic        mask_force, mask_keep, cmd_error;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    gcmd_decoder u_dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .tpage_x(tpage_x), .tpage_y(tpage_y),
        .blend_mode(blend_mode), .tex_depth(tex_depth), .dither_en(dither_en),
        .disp_draw_en(disp_draw_en), .tex_off(tex_off), .rect_flip_x(rect_flip_x),
        .rect_flip_y(rect_flip_y), .twin_mask_x(twin_mask_x), .twin_mask_y(twin_mask_y),
        .twin_ofs_x(twin_ofs_x), .twin_ofs_y(twin_ofs_y), .clip_x0(clip_x0),
        .clip_y0(clip_y0), .clip_x1(clip_x1), .clip_y1(clip_y1), .org_x(org_x),
        .org_y(org_y), .mask_force(mask_force), .mask_keep(mask_keep),
        .cmd_error(cmd_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; word_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Offer one word for one cycle, then wait until it has been applied.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        word_valid = 1'b1; word_data = w;
        @(negedge clk);
        word_valid = 1'b0; word_data = 32'hE5FFFFFF;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 tpage_x", 32'(tpage_x), 0);
        check("R1 mode bits", {25'd0, tpage_y, blend_mode, tex_depth, dither_en, disp_draw_en},
              0);
        check("R1 clip", {clip_x0, clip_y0, clip_x1}, 0);
        check("R1 org", {org_x, org_y}, 0);
        check("R1 mask/err", {29'd0, mask_force, mask_keep, cmd_error}, 0);
        check("R12 ready out of reset", 32'(word_ready), 1);
    endtask

    task automatic t_mode();
        send(32'hE1FF2ADA);
        check("R4 page x", 32'(tpage_x), 32'hA);
        check("R4 page y", 32'(tpage_y), 1);
        check("R4 blend", 32'(blend_mode), 2);
        check("R4 depth", 32'(tex_depth), 1);
        check("R4 flags", {27'd0, dither_en, disp_draw_en, tex_off, rect_flip_x, rect_flip_y},
              32'b10101);
        check("R4 no error", 32'(cmd_error), 0);
    endtask

    task automatic t_depth3();
        send(32'hE1000180);
        check("R5 error set", 32'(cmd_error), 1);
        check("R5 depth kept", 32'(tex_depth), 1);
        check("R5 page kept", 32'(tpage_x), 32'hA);
    endtask

    task automatic t_texwin();
        send(32'hE205547F);
        check("R6 window", {12'd0, twin_mask_x, twin_mask_y, twin_ofs_x, twin_ofs_y},
              {12'd0, 5'h1F, 5'h03, 5'h15, 5'h0A});
    endtask

    task automatic t_clip_burst();
        @(negedge clk);
        word_valid = 1'b1; word_data = 32'hE30AAD23;
        @(negedge clk);
        word_data = 32'hE40007FF;
        @(negedge clk);
        word_valid = 1'b0;
        @(negedge clk);
        check("R7 upper-left x", 32'(clip_x0), 32'h123);
        check("R7 upper-left y", 32'(clip_y0), 32'h2AB);
        check("R7 lower-right x", 32'(clip_x1), 32'h3FF);
        check("R7 lower-right y", 32'(clip_y1), 32'h001);
    endtask

    task automatic t_origin();
        // latency: nothing visible one edge after acceptance
        @(negedge clk);
        word_valid = 1'b1; word_data = 32'hE50967FB;
        @(negedge clk);
        word_valid = 1'b0;
        check("R2 not yet applied", {org_x, org_y}, 0);
        @(negedge clk);
        check("R2 applied second edge", 32'(org_x), 32'hFFFB);
        check("R8 negative x", 32'(org_x), 32'hFFFB);
        check("R8 positive y", 32'(org_y), 32'h012C);
        send(32'hE52003FF);
        check("R8 max x", 32'(org_x), 32'h03FF);
        check("R8 min y", 32'(org_y), 32'hFC00);
    endtask

    task automatic t_mask();
        send(32'hE6000002);
        check("R9 keep only", {30'd0, mask_force, mask_keep}, 32'b01);
        send(32'hE6000001);
        check("R9 force only", {30'd0, mask_force, mask_keep}, 32'b10);
    endtask

    task automatic t_nop();
        send(32'h00FFFFFF);
        check("R3 org kept", {org_x, org_y}, {16'h03FF, 16'hFC00});
        check("R3 mask kept", {30'd0, mask_force, mask_keep}, 32'b10);
        check("R3 no error", 32'(cmd_error), 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        word_valid = 1'b0; word_data = 32'hE5000000;
        repeat (4) @(negedge clk);
        word_data = 32'hE6000003;
        repeat (3) @(negedge clk);
        check("R11 org unchanged", {org_x, org_y}, {16'h03FF, 16'hFC00});
        check("R11 mask unchanged", {30'd0, mask_force, mask_keep}, 32'b10);
    endtask

    task automatic t_bad_op();
        send(32'hE7123456);
        check("R10 error set", 32'(cmd_error), 1);
        check("R10 org unchanged", {org_x, org_y}, {16'h03FF, 16'hFC00});
        check("R10 mask unchanged", {30'd0, mask_force, mask_keep}, 32'b10);
        send(32'hE6000003);
        check("R10 later command applied", {30'd0, mask_force, mask_keep}, 32'b11);
        check("R10 error sticky", 32'(cmd_error), 1);
        check("R12 ready after error", 32'(word_ready), 1);
    endtask

    initial begin
        @(negedge clk);
        check("R12 ready in reset", 32'(word_ready), 1);
        do_reset();
        t_reset();
        t_mode();
        t_texwin();
        t_clip_burst();
        t_origin();
        t_mask();
        t_nop();
        t_idle();
        t_bad_op();
        t_depth3();
        do_reset();
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule